// File: doc/BRIEF.md
# Dual-Channel One-Bit Accumulate-and-Dump Receiver Front End

This block takes the one-bit comparator decisions of a quadrature receiver and turns them into periodic count totals. Each of the two channels (I and Q) delivers a pair of bits on every clock: one from the positive leg and one from the negative leg. The block combines two consecutive pairs into a four-bit group, corrects the sign of the negative-leg bits, counts the ones, and adds the count to a running total for the channel.

A free-running interval timer, shared by both channels, issues a dump strobe once every `CLK_HZ / (RATE_HZ * 4)` clocks. On that strobe each channel presents its total and restarts from zero in the same step, so every group lands in exactly one interval. A group that is only half assembled when the strobe fires finishes in the next interval. The block also drives four sigma-delta feedback pins that carry the inverse of the sampled inputs, one clock late.

The dump output has a valid flag and no ready input. The consumer must take each total in the cycle its valid pulse is high. The block cannot stall, because stalling would drop comparator samples. The totals are held until the next pulse, so a slow reader has a full interval to capture them.

Top module: `acqd_top`

## Requirements
- R1: On every clock, `fb_out` takes the bitwise inverse of `{i_pos, i_neg, q_pos, q_neg}` sampled at that edge, in that bit order with `i_pos` in bit 3. It is 4'b0000 during reset.
- R2: Per channel, two consecutive pairs form a group `{pos_first, neg_first, pos_second, neg_second}` (bit 3 first). The group adds popcount(group XOR 4'b0101) to the total, a value from 0 to 4.
- R3: The dump strobe occurs every `CLK_HZ / (RATE_HZ * 4)` clocks (integer division). The first strobe is on the clock edge that number of edges after reset is released.
- R4: A dump reports the sum of all groups completed since the previous dump, including a group completed on the strobe edge itself. The internal total is zero right after the dump.
- R5: A group whose first half was captured on the strobe edge is completed and counted in the following interval, not dropped.
- R6: `dump_valid` is a single-clock pulse per strobe (for a period above one). `i_total` and `q_total` keep their value until the next pulse. There is no back-pressure.
- R7: The I and Q channels are dumped on the same edge by the same strobe.
- R8: The totals never overflow. Their width holds at least 2 × period + 4.
- R9: After reset the totals and `dump_valid` are zero. The first pair after reset is the first half of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_pos | input | 1 | I channel positive-leg comparator bit |
| i_neg | input | 1 | I channel negative-leg comparator bit |
| q_pos | input | 1 | Q channel positive-leg comparator bit |
| q_neg | input | 1 | Q channel negative-leg comparator bit |
| fb_out | output | 4 | Inverted registered inputs {i_pos,i_neg,q_pos,q_neg} |
| i_total | output | TOT_W | I channel dumped total |
| q_total | output | TOT_W | Q channel dumped total |
| dump_valid | output | 1 | One-clock pulse marking a new dump |

## Verification
The assertions check the following on every cycle:
- the feedback pins follow the inverse of the previous inputs;
- the interval counter stays inside its period;
- the running total is zero while the dump is valid and stays below its bound;
- the valid pulse lasts one clock;
- the dumped totals hold between pulses;
- both channels dump together.

Only the bench scenarios can show that the dumped numbers are right. This covers the sign correction across mixed bit patterns, the exact interval length, and the half-group carry. With an odd period, an all-maximum input must alternate between dumps of 16 and 20.

// File: rtl/acqd_pkg.sv
package acqd_pkg;

  localparam int LEGS = 2;
  localparam int GROUP_BITS = 4;
  localparam logic [GROUP_BITS-1:0] SIGN_FIX = 4'b0101;

  typedef struct packed {
    logic pos;
    logic neg;
  } leg_pair_t;

  function automatic int dump_period(input int clk_hz, input int rate_hz);
    return clk_hz / (rate_hz * 4);
  endfunction

  function automatic int total_width(input int period);
    return $clog2(2 * period + 5);
  endfunction

  function automatic logic [2:0] group_ones(input logic [GROUP_BITS-1:0] grp);
    logic [2:0] n;
    n = 3'd0;
    for (int b = 0; b < GROUP_BITS; b++) n = n + {2'b00, grp[b]};
    return n;
  endfunction

endpackage

// File: rtl/acqd_strobe_timer.sv
module acqd_strobe_timer #(
  parameter int PERIOD = 375,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign strobe = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (strobe) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R3: the interval counter never leaves its period
  assert_count_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R3: a strobe always restarts the count
  assert_restart_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (cnt_q == '0));

endmodule

// File: rtl/acqd_feedback.sv
module acqd_feedback #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] fb_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= '0;
    else fb_q <= ~raw_in;
  end

  // R1: feedback is the inverse of the previous cycle's inputs
  assert_fb_inverse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fb_q == ~$past(raw_in)));

endmodule

// File: rtl/acqd_channel.sv
module acqd_channel
  import acqd_pkg::*;
#(
  parameter int PERIOD = 375,
  parameter int TOT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  leg_pair_t        pair,
  output logic [TOT_W-1:0] total,
  output logic             valid
);

  localparam logic [TOT_W-1:0] MAX_TOT = TOT_W'(2 * PERIOD + 4);

  logic             second_half_q;
  leg_pair_t        first_q;
  logic [TOT_W-1:0] acc_q;
  logic [2:0]       grp_cnt;
  logic [TOT_W-1:0] acc_next;

  always_comb begin
    grp_cnt = 3'd0;
    if (second_half_q)
      grp_cnt = group_ones({first_q.pos, first_q.neg, pair.pos, pair.neg} ^ SIGN_FIX);
    acc_next = acc_q + TOT_W'(grp_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_half_q <= 1'b0;
      first_q       <= '0;
    end else begin
      second_half_q <= ~second_half_q;
      if (!second_half_q) first_q <= pair;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      total <= '0;
      valid <= 1'b0;
    end else begin
      valid <= strobe;
      if (strobe) begin
        total <= acc_next;
        acc_q <= '0;
      end else begin
        acc_q <= acc_next;
      end
    end
  end

  // R4: the running total restarts while the dump is presented
  assert_clear_on_dump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (acc_q <= TOT_W'(4)));

  // R8: the running total stays within its guaranteed bound
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= MAX_TOT);

  // R6: dumped data holds between pulses
  assert_hold_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(total));

  generate
    if (PERIOD > 1) begin : g_pulse
      // R6: the valid flag is a single-clock pulse
      assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    end
  endgenerate

endmodule

// File: rtl/acqd_top.sv
module acqd_top
  import acqd_pkg::*;
#(
  parameter int CLK_HZ = 300_000_000,
  parameter int RATE_HZ = 200_000,
  localparam int PERIOD = dump_period(CLK_HZ, RATE_HZ),
  localparam int TOT_W = total_width(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_pos,
  input  logic             i_neg,
  input  logic             q_pos,
  input  logic             q_neg,
  output logic [3:0]       fb_out,
  output logic [TOT_W-1:0] i_total,
  output logic [TOT_W-1:0] q_total,
  output logic             dump_valid
);

  localparam int NCH = 2;

  logic             strobe;
  leg_pair_t        pair_v  [NCH];
  logic [TOT_W-1:0] total_v [NCH];
  logic             valid_v [NCH];

  assign pair_v[0] = '{pos: i_pos, neg: i_neg};
  assign pair_v[1] = '{pos: q_pos, neg: q_neg};

  acqd_strobe_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .strobe(strobe)
  );

  acqd_feedback #(.N(NCH * LEGS)) u_fb (
    .clk(clk), .rst_n(rst_n),
    .raw_in({i_pos, i_neg, q_pos, q_neg}),
    .fb_q(fb_out)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      acqd_channel #(.PERIOD(PERIOD), .TOT_W(TOT_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .pair(pair_v[ch]), .total(total_v[ch]), .valid(valid_v[ch])
      );
    end
  endgenerate

  assign i_total    = total_v[0];
  assign q_total    = total_v[1];
  assign dump_valid = valid_v[0];

  // R7: both channels dump on the same edge
  assert_shared_dump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_v[0] == valid_v[1]);

  // R3: a dump follows each strobe by one register
  assert_dump_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> dump_valid);

endmodule

// File: tb/acqd_top_test.sv
module acqd_top_test;

  localparam int CLK_HZ = 900_000;
  localparam int RATE_HZ = 25_000;
  localparam int P = CLK_HZ / (RATE_HZ * 4);
  localparam int TW = $clog2(2 * P + 5);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_pos = 1'b0, i_neg = 1'b0, q_pos = 1'b0, q_neg = 1'b0;
  logic [3:0] fb_out;
  logic [TW-1:0] i_total, q_total;
  logic dump_valid;

  int checks = 0;
  int fails = 0;

  // bench model state
  int m_cnt, m_half, m_ti, m_tq, m_hi, m_hq, last_i, last_q, last_dump_i;

  always #4 clk = ~clk;

  acqd_top #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .i_pos(i_pos), .i_neg(i_neg),
    .q_pos(q_pos), .q_neg(q_neg), .fb_out(fb_out),
    .i_total(i_total), .q_total(q_total), .dump_valid(dump_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic step(input logic ip, input logic in, input logic qp, input logic qn,
                      input string tag);
    int gi, gq;
    bit dump;
    i_pos = ip; i_neg = in; q_pos = qp; q_neg = qn;
    @(posedge clk);
    gi = 0; gq = 0;
    if (m_half == 1) begin
      gi = m_hi + int'(ip) + int'(!in);
      gq = m_hq + int'(qp) + int'(!qn);
    end else begin
      m_hi = int'(ip) + int'(!in);
      m_hq = int'(qp) + int'(!qn);
    end
    m_half = 1 - m_half;
    dump = (m_cnt == P - 1);
    if (dump) begin
      last_i = m_ti + gi; last_q = m_tq + gq;
      m_ti = 0; m_tq = 0; m_cnt = 0;
    end else begin
      m_ti += gi; m_tq += gq; m_cnt++;
    end
    #2;
    check(fb_out == ~{ip, in, qp, qn}, "R1 feedback", int'(fb_out), int'(~{ip, in, qp, qn}));
    check(dump_valid == dump, "R3/R6 dump_valid timing", int'(dump_valid), int'(dump));
    check(int'(i_total) == last_i, {tag, " i_total"}, int'(i_total), last_i);
    check(int'(q_total) == last_q, "R7 q_total", int'(q_total), last_q);
    if (dump) last_dump_i = int'(i_total);
    @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    i_pos = 1'b1; i_neg = 1'b0; q_pos = 1'b1; q_neg = 1'b0;
    repeat (3) @(negedge clk);
    check(dump_valid == 1'b0, "R9 reset valid", int'(dump_valid), 0);
    check(i_total == '0, "R9 reset i_total", int'(i_total), 0);
    check(q_total == '0, "R9 reset q_total", int'(q_total), 0);
    check(fb_out == 4'b0000, "R1 reset feedback", int'(fb_out), 0);
    m_cnt = 0; m_half = 0; m_ti = 0; m_tq = 0; m_hi = 0; m_hq = 0;
    last_i = 0; last_q = 0; last_dump_i = 0;
    rst_n = 1'b1;
  endtask

  // R5 and R2: all-maximum input with an odd period alternates 16 and 20
  task automatic t_carry_max();
    reset_dut();
    for (int k = 1; k <= 4 * P; k++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, "R5 carry");
      if (k == P) check(last_dump_i == 16, "R5 first interval", last_dump_i, 16);
      if (k == 2 * P) check(last_dump_i == 20, "R5 carried group", last_dump_i, 20);
    end
  endtask

  // R2: positive low, negative high counts nothing
  task automatic t_min();
    reset_dut();
    for (int k = 1; k <= 3 * P; k++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, "R2 zero");
      if (k == 2 * P) check(last_dump_i == 0, "R2 minimum group", last_dump_i, 0);
    end
  endtask

  // R2: mixed patterns, I and Q differ
  task automatic t_mixed();
    reset_dut();
    for (int k = 0; k < 4 * P; k++)
      step(k[0], k[1], k[1], ~k[0], "R2 mixed");
  endtask

  // R4 and R7: pseudo-random streams over many intervals
  task automatic t_lfsr();
    logic [15:0] lf;
    reset_dut();
    lf = 16'hACE1;
    for (int k = 0; k < 30 * P; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[3], lf[7], lf[11], "R4 lfsr");
    end
  endtask

  // R8: sustained maximum never wraps; worst interval is 20 = 2*P+2
  task automatic t_bound();
    reset_dut();
    for (int k = 0; k < 6 * P; k++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, "R8 bound");
      check(last_dump_i <= 2 * P + 4, "R8 no overflow", last_dump_i, 2 * P + 4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_carry_max();
    t_min();
    t_mixed();
    t_lfsr();
    t_bound();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule